// File: doc/BRIEF.md
# Cascadable LCD Multiplex Timing Sequencer

This block produces the scan timing for a quarter-duty multiplexed LCD: four backplanes, one active at a time, and thirty-two frontplanes whose on/off state is taken from a 128-bit display image. It runs from the display oscillator clock. Each backplane slot lasts a fixed number of oscillator cycles. The default is 250, so a full frame takes 1000 cycles. A drive-polarity bit flips on every frame so that the segment drive has no DC component.

Several copies can scan one panel in step. A 3-bit strap decides the role. The all-ones strap makes a device the timing master. The master drives a one-cycle frame-sync pulse on the first cycle of every backplane-0 slot. Every other strap value makes the device a slave. A slave treats frame sync as an input and realigns its slot counter to the pulse. The analog drive levels and the oscillator itself belong to other blocks.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While reset is held, and for the two clock edges after it is released, the block stays at the first cycle of backplane 0. In that state bp_index=0, bp_active=4'b0001, polarity=0 and fsync_out=0. Counting starts on the third rising edge after release.
- R2: Each backplane slot lasts SLOT_DIV clocks. Slots visit backplanes 0,1,2,3 and then wrap to 0, so one frame is 4*SLOT_DIV clocks.
- R3: bp_active has exactly one bit set, and that bit is bit bp_index.
- R4: fp_on[f] equals image[bp_index*32 + f]. A 1 means the segment is on.
- R5: polarity inverts on each natural wrap from the last cycle of backplane 3 to the first cycle of backplane 0.
- R6: fsync_oe is 1 exactly when strap_addr is 3'b111 (master). Every other value, 3'b000 included, gives slave mode with fsync_oe=0.
- R7: In master mode, fsync_out is high for exactly the first cycle of each backplane-0 slot, and fsync_in has no effect on the timing.
- R8: In slave mode, fsync_out stays low.
- R9: In slave mode, fsync_in high at a rising edge puts the block at the second cycle of backplane 0 after that edge. This matches a master that pulsed in the previous cycle. polarity inverts on that edge unless the slave was already at the first cycle of backplane 0.
- R10: A slave that receives no frame sync free-runs with the same timing as a master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_addr | input | 3 | Role strap; 3'b111 means master |
| fsync_in | input | 1 | Frame sync from the master (used in slave mode) |
| image | input | 128 | Latched display image; bit b*32+f belongs to backplane b, frontplane f |
| fsync_out | output | 1 | Frame sync pulse (master mode) |
| fsync_oe | output | 1 | Drive enable for the frame sync pin |
| bp_index | output | 2 | Index of the active backplane |
| bp_active | output | 4 | One-hot active backplane |
| fp_on | output | 32 | Per-frontplane segment-on select for the active backplane |
| polarity | output | 1 | Drive polarity phase of the current frame |

## Verification
A slot counter that slips by even one cycle moves the bp_index change away from its expected cycle. This shows up within one slot, and fp_on switches to the wrong image row in the same cycle. A polarity error shows within one frame. A slave that misses its resync, or loads the wrong phase, shows up in the cycle right after the pulse: its position and polarity no longer match a model that tracks the master. The bench therefore compares every output on every cycle against an arithmetic position model. It sweeps the sync pulse across every frame position and sweeps all strap values.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam logic [2:0] MASTER_STRAP = 3'b111;
  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_e;
endpackage

// File: rtl/lcd_seq_rst_sync.sv
module lcd_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lcd_seq_role.sv
module lcd_seq_role
  import lcd_seq_pkg::*;
(
  input  logic [2:0] strap_addr,
  output role_e      role
);
  always_comb begin
    role = (strap_addr == MASTER_STRAP) ? ROLE_MASTER : ROLE_SLAVE;
  end
endmodule

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
  parameter int NUM_BP   = 4,
  parameter int SLOT_DIV = 250
) (
  input  logic                      clk,
  input  logic                      srst_n,
  input  logic                      resync,
  output logic [$clog2(NUM_BP)-1:0] slot,
  output logic                      frame_start,
  output logic                      polarity
);
  localparam int DW = $clog2(SLOT_DIV);
  localparam int SW = $clog2(NUM_BP);
  localparam logic [DW-1:0] DIV_LAST = DW'(SLOT_DIV - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(NUM_BP - 1);

  logic [DW-1:0] div_q, div_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          pol_q, pol_d;
  logic          div_en, slot_en, pol_en;

  assign frame_start = (div_q == '0) && (slot_q == '0);

  always_comb begin
    div_en  = 1'b1;
    slot_en = resync || (div_q == DIV_LAST);
    pol_en  = resync ? !frame_start : ((div_q == DIV_LAST) && (slot_q == SLOT_LAST));
    if (resync) begin
      div_d  = DW'(1);
      slot_d = '0;
    end else if (div_q == DIV_LAST) begin
      div_d  = '0;
      slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + SW'(1);
    end else begin
      div_d  = div_q + DW'(1);
      slot_d = slot_q;
    end
    pol_d = !pol_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      div_q  <= '0;
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      if (div_en)  div_q  <= div_d;
      if (slot_en) slot_q <= slot_d;
      if (pol_en)  pol_q  <= pol_d;
    end
  end

  assign slot     = slot_q;
  assign polarity = pol_q;

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!resync && div_q != DIV_LAST) |=> $stable(slot_q)); // R2
  AST_POL_WRAP: assert property (@(posedge clk) disable iff (!srst_n)
    (!resync && div_q == DIV_LAST && slot_q == SLOT_LAST) |=> (pol_q != $past(pol_q))); // R5
  AST_RESYNC_PHASE: assert property (@(posedge clk) disable iff (!srst_n)
    resync |=> (div_q == DW'(1) && slot_q == '0)); // R9
endmodule

// File: rtl/lcd_seq_segsel.sv
module lcd_seq_segsel #(
  parameter int NUM_BP = 4,
  parameter int NUM_FP = 32
) (
  input  logic [NUM_BP*NUM_FP-1:0]  image,
  input  logic [$clog2(NUM_BP)-1:0] slot,
  output logic [NUM_BP-1:0]         bp_active,
  output logic [NUM_FP-1:0]         fp_on
);
  logic [NUM_FP-1:0] row [NUM_BP];

  for (genvar b = 0; b < NUM_BP; b++) begin : g_row
    assign row[b]       = image[b*NUM_FP +: NUM_FP];
    assign bp_active[b] = (slot == b[$clog2(NUM_BP)-1:0]);
  end

  assign fp_on = row[slot];

  always_comb begin
    AST_BP_ONEHOT: assert ($countones(bp_active) == 1); // R3
  end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int NUM_BP   = 4,
  parameter int NUM_FP   = 32,
  parameter int SLOT_DIV = 250
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 strap_addr,
  input  logic                       fsync_in,
  input  logic [NUM_BP*NUM_FP-1:0]   image,
  output logic                       fsync_out,
  output logic                       fsync_oe,
  output logic [$clog2(NUM_BP)-1:0]  bp_index,
  output logic [NUM_BP-1:0]          bp_active,
  output logic [NUM_FP-1:0]          fp_on,
  output logic                       polarity
);
  logic  srst_n;
  role_e role;
  logic  is_master;
  logic  resync;
  logic  frame_start;

  lcd_seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  lcd_seq_role u_role (.strap_addr(strap_addr), .role(role));

  assign is_master = (role == ROLE_MASTER);
  assign resync    = !is_master && fsync_in;

  lcd_seq_timer #(.NUM_BP(NUM_BP), .SLOT_DIV(SLOT_DIV)) u_timer (
    .clk(clk), .srst_n(srst_n), .resync(resync),
    .slot(bp_index), .frame_start(frame_start), .polarity(polarity)
  );

  lcd_seq_segsel #(.NUM_BP(NUM_BP), .NUM_FP(NUM_FP)) u_seg (
    .image(image), .slot(bp_index), .bp_active(bp_active), .fp_on(fp_on)
  );

  assign fsync_oe  = is_master;
  assign fsync_out = is_master && frame_start && srst_n;

  AST_FS_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    (strap_addr != 3'b111) |-> !fsync_out); // R8
  AST_FS_ON_BP0: assert property (@(posedge clk) disable iff (!srst_n)
    fsync_out |-> (bp_index == '0)); // R7
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    (fsync_out && $stable(strap_addr)) |=> !fsync_out); // R7
endmodule

// File: tb/lcd_mux_sequencer_test.sv
module lcd_mux_sequencer_test;
  localparam int PER   = 10;
  localparam int DIV   = 5;
  localparam int FRAME = 4 * DIV;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   strap_addr = 3'b111;
  logic         fsync_in = 1'b0;
  logic [127:0] image = '0;
  logic         fsync_out, fsync_oe, polarity;
  logic [1:0]   bp_index;
  logic [3:0]   bp_active;
  logic [31:0]  fp_on;

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b1;

  int m_pos; bit m_pol; int m_rel;

  lcd_mux_sequencer #(.NUM_BP(4), .NUM_FP(32), .SLOT_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .fsync_in(fsync_in),
    .image(image), .fsync_out(fsync_out), .fsync_oe(fsync_oe),
    .bp_index(bp_index), .bp_active(bp_active), .fp_on(fp_on), .polarity(polarity)
  );

  always #(PER/2) clk = ~clk;

  // Position model from the requirements: R1 release delay, R2/R5 wrap, R9 resync
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos <= 0; m_pol <= 1'b0; m_rel <= 0;
    end else if (m_rel < 2) begin
      m_rel <= m_rel + 1;
    end else if (strap_addr != 3'b111 && fsync_in) begin
      if (m_pos != 0) m_pol <= ~m_pol;
      m_pos <= 1;
    end else if (m_pos == FRAME - 1) begin
      m_pos <= 0; m_pol <= ~m_pol;
    end else begin
      m_pos <= m_pos + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      int slot_e;
      slot_e = m_pos / DIV;
      chk("R1/R2 bp_index", 32'(bp_index), 32'(slot_e));
      chk("R3 bp_active", 32'(bp_active), 32'(1) << slot_e);
      chk("R4 fp_on", fp_on, 32'(image >> (slot_e * 32)));
      chk("R5 polarity", 32'(polarity), 32'(m_pol));
      chk("R6 fsync_oe", 32'(fsync_oe), 32'(strap_addr == 3'b111));
      chk("R7/R8 fsync_out", 32'(fsync_out),
          32'(strap_addr == 3'b111 && m_pos == 0 && m_rel == 2 && rst_n));
    end
  end

  function automatic logic [127:0] gen_img(input int seed);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'(seed * 32'h9E3779B1 + i * 32'h7F4A7C15);
    return v;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(PER * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state held through release delay
    step(3);
    rst_n = 1'b1;
    // R2..R5, R7: master over several frames, changing image, noisy fsync_in ignored
    for (int c = 0; c < 4 * FRAME; c++) begin
      if (c % 7 == 0) image = gen_img(c);
      fsync_in = (c % 3 == 1);
      step(1);
    end
    fsync_in = 1'b0;
    // R1: asynchronous reset mid-run
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(FRAME);
    // R8, R10: slave free-running
    strap_addr = 3'b101;
    step(2 * FRAME + 3);
    // R9: sync pulse swept across every frame position
    for (int d = 0; d < FRAME + 2; d++) begin
      image = gen_img(d + 100);
      fsync_in = 1'b1; step(1); fsync_in = 1'b0;
      step(d);
    end
    // R6, R9: reserved strap 000 acts as slave
    strap_addr = 3'b000;
    step(3);
    fsync_in = 1'b1; step(1); fsync_in = 1'b0; step(FRAME);
    // R6: strap sweep
    for (int s = 0; s < 8; s++) begin
      strap_addr = 3'(s); step(FRAME + 1);
    end
    chk_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule